// File: doc/BRIEF.md
# PCI Target Claim and Device-Select Sequencer

This block decides whether a PCI target takes part in a transaction and then controls the three target response strobes. It samples the address and command during the address phase. An access is claimed when it is a memory command whose address falls in one fixed, naturally aligned window. A type 0 configuration access is also claimed when the slot select input is high. Once it has claimed an access, the block pulls DEVSEL# low after one, two or three clocks, as the timing selector chooses. It reports that choice on a two-bit status field.

During the data phases the block asserts TRDY# whenever the back end says it is ready. It tracks the dword address of the burst. If the initiator tries to run past the last dword of the window, the block disconnects with STOP#. A back-end abort request ends the access with target-abort signalling. All control signals are active low and are sampled on the rising clock edge.

Top module: `devsel_claim`

## Requirements
- R1: While reset is held, and on the first clock after it, devselN, trdyN and stopN are all high.
- R2: An address phase is a rising edge where frameN is low and the previous sampled edge saw frameN and irdyN both high. Only an address phase can start a claim. A memory access is claimed when the command on cbeN is 4'b0110 (read) or 4'b0111 (write) and adBus[31:WIN_BITS] equals BASE_ADDR[31:WIN_BITS]. Any other command or address is not claimed, and devselN stays high.
- R3: A configuration access is claimed only when the command is 4'b1010 (read) or 4'b1011 (write), idsel is high and adBus[1:0] is 2'b00 (type 0). A type 1 access (adBus[1:0] = 2'b01), or one with idsel low, is not claimed.
- R4: After a claimed address phase, devselN goes low 1, 2 or 3 clocks later for timingSel 2'b00 (fast), 2'b01 (medium) or 2'b10 (slow). The code 2'b11 behaves as slow.
- R5: statusTiming equals timingSel for codes 2'b00, 2'b01 and 2'b10. For 2'b11 it shows 2'b10, and 2'b00 means fast.
- R6: trdyN is never low while devselN is high. stopN is never low while devselN is high, except for target-abort.
- R7: Once devselN is low it stays low while frameN is low, unless there is an abort. On normal completion, devselN rises in the same clock that trdyN or stopN rises.
- R8: Each completed data phase advances the burst dword address. If the phase on the window's last dword completes while frameN is still low, the next clock has stopN low and trdyN high (disconnect). stopN and devselN are then released together once frameN is sampled high. A configuration access is treated as a one-dword window.
- R9: If abortReq is sampled high during the data phases, the next clock has devselN high and stopN low. stopN is released after frameN is sampled high.
- R10: trdyN goes low one clock after devselN when dataReady is high. After a transaction ends, one turnaround clock passes before a new claim is possible. An address that follows the final data phase with no idle bus clock between them is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Initiator cycle frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| adBus | input | 32 | Multiplexed address/data bus |
| cbeN | input | 4 | Command during address phase, byte enables after |
| idsel | input | 1 | Configuration slot select |
| timingSel | input | 2 | Device-select delay code |
| dataReady | input | 1 | Back end can complete a data phase |
| abortReq | input | 1 | Back end requests target-abort |
| devselN | output | 1 | Device select, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Target stop, active low |
| statusTiming | output | 2 | Reported device-select timing code |

## Verification
A delay counter loaded with the wrong value shows up at once as devselN falling on the wrong clock after the address phase. The bench measures that clock exactly for every timing code. A burst index that drifts moves the disconnect to a different data phase, so the count of completed transfers before stopN falls no longer matches the distance to the window edge. A state machine stuck in a data or stop state leaves a strobe low after frameN has gone high. The bench sees this on the very clock after the final phase, where all three outputs must be high together.

// File: rtl/devsel_claim_pkg.sv
`timescale 1ns/1ps
package devsel_claim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_DISC,
    ST_ABORT,
    ST_TURN
  } claimState_t;

  typedef struct packed {
    logic loadAddr;
    logic advance;
    logic decDelay;
  } dpStrobe_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam logic [1:0] TIM_FAST = 2'b00;
  localparam logic [1:0] TIM_MED  = 2'b01;
  localparam logic [1:0] TIM_SLOW = 2'b10;

endpackage

// File: rtl/devsel_claim_dp.sv
`timescale 1ns/1ps
module devsel_claim_dp
  import devsel_claim_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int unsigned WIN_BITS  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] adBus,
  input  logic [3:0]        cbeN,
  input  logic              idsel,
  input  logic [1:0]        timingSel,
  input  dpStrobe_t         strobe,
  output logic              memHit,
  output logic              cfgHit,
  output logic [1:0]        waitCycles,
  output logic              delayDone,
  output logic              atBoundary,
  output logic [1:0]        statusTiming
);

  localparam int unsigned IDX_W = WIN_BITS - 2;
  localparam logic [IDX_W-1:0] IDX_LAST = '1;
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  logic [IDX_W-1:0] idxQ;
  logic             cfgQ;
  logic [1:0]       delayQ;

  // Address-phase decode, valid only while the control samples an address phase
  always_comb begin
    memHit = ((cbeN == CMD_MEM_RD) || (cbeN == CMD_MEM_WR)) &&
             (adBus[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
    cfgHit = ((cbeN == CMD_CFG_RD) || (cbeN == CMD_CFG_WR)) &&
             idsel && (adBus[1:0] == 2'b00);
  end

  // Extra clocks to wait after the address edge before DEVSEL
  always_comb begin
    unique case (timingSel)
      TIM_FAST: waitCycles = 2'd0;
      TIM_MED:  waitCycles = 2'd1;
      default:  waitCycles = 2'd2;
    endcase
    statusTiming = (timingSel == 2'b11) ? TIM_SLOW : timingSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= '0;
      cfgQ   <= 1'b0;
      delayQ <= 2'd0;
    end else begin
      if (strobe.loadAddr) begin
        idxQ   <= adBus[WIN_BITS-1:2];
        cfgQ   <= cfgHit && !memHit;
        delayQ <= waitCycles;
      end else begin
        if (strobe.advance)  idxQ   <= idxQ + IDX_ONE;
        if (strobe.decDelay) delayQ <= delayQ - 2'd1;
      end
    end
  end

  assign delayDone  = (delayQ == 2'd1);
  assign atBoundary = cfgQ || (idxQ == IDX_LAST);

  p_delay_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    delayQ <= 2'd2);

  p_burst_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.loadAddr) |=> (idxQ == $past(idxQ) + IDX_ONE));

endmodule

// File: rtl/devsel_claim_ctrl.sv
`timescale 1ns/1ps
module devsel_claim_ctrl
  import devsel_claim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       dataReady,
  input  logic       abortReq,
  input  logic       memHit,
  input  logic       cfgHit,
  input  logic [1:0] waitCycles,
  input  logic       delayDone,
  input  logic       atBoundary,
  output dpStrobe_t  strobe,
  output logic       devselN,
  output logic       trdyN,
  output logic       stopN
);

  claimState_t stateQ, stateNxt;
  logic prevIdleQ;
  logic devselNxt, trdyNxt, stopNxt;
  logic addrPhase, xfer;

  assign addrPhase = (stateQ == ST_IDLE) && !frameN && prevIdleQ;
  assign xfer      = !trdyN && !irdyN;

  always_comb begin
    stateNxt  = stateQ;
    devselNxt = devselN;
    trdyNxt   = trdyN;
    stopNxt   = stopN;
    strobe    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (addrPhase && (memHit || cfgHit)) begin
          strobe.loadAddr = 1'b1;
          if (waitCycles == 2'd0) begin
            devselNxt = 1'b0;
            stateNxt  = ST_DATA;
          end else begin
            stateNxt  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (delayDone) begin
          devselNxt = 1'b0;
          stateNxt  = ST_DATA;
        end else begin
          strobe.decDelay = 1'b1;
        end
      end
      ST_DATA: begin
        if (abortReq) begin
          devselNxt = 1'b1;
          trdyNxt   = 1'b1;
          stopNxt   = 1'b0;
          stateNxt  = ST_ABORT;
        end else if (xfer) begin
          strobe.advance = 1'b1;
          if (frameN) begin
            devselNxt = 1'b1;
            trdyNxt   = 1'b1;
            stateNxt  = ST_TURN;
          end else if (atBoundary) begin
            trdyNxt  = 1'b1;
            stopNxt  = 1'b0;
            stateNxt = ST_DISC;
          end else begin
            trdyNxt = !dataReady;
          end
        end else if (frameN && irdyN) begin
          devselNxt = 1'b1;
          trdyNxt   = 1'b1;
          stateNxt  = ST_TURN;
        end else begin
          trdyNxt = trdyN && !dataReady;
        end
      end
      ST_DISC: begin
        if (frameN) begin
          devselNxt = 1'b1;
          stopNxt   = 1'b1;
          stateNxt  = ST_TURN;
        end
      end
      ST_ABORT: begin
        if (frameN) begin
          stopNxt  = 1'b1;
          stateNxt = ST_TURN;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      prevIdleQ <= 1'b0;
      devselN   <= 1'b1;
      trdyN     <= 1'b1;
      stopN     <= 1'b1;
    end else begin
      stateQ    <= stateNxt;
      prevIdleQ <= frameN && irdyN;
      devselN   <= devselNxt;
      trdyN     <= trdyNxt;
      stopN     <= stopNxt;
    end
  end

  p_trdy_under_devsel_r6: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  p_stop_under_devsel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && stateQ != ST_ABORT) |-> !devselN);

  p_hold_devsel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!devselN && !frameN && !abortReq) |=> !devselN);

  p_release_together_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devselN) |-> (trdyN && (stopN || $past(abortReq))));

  p_disconnect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DATA && xfer && !frameN && atBoundary && !abortReq)
      |=> (!stopN && trdyN && !devselN));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DATA && abortReq) |=> (devselN && !stopN));

  p_turnaround_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TURN) |=> devselN);

endmodule

// File: rtl/devsel_claim.sv
`timescale 1ns/1ps
module devsel_claim
  import devsel_claim_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int unsigned WIN_BITS  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic [31:0] adBus,
  input  logic [3:0]  cbeN,
  input  logic        idsel,
  input  logic [1:0]  timingSel,
  input  logic        dataReady,
  input  logic        abortReq,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN,
  output logic [1:0]  statusTiming
);

  dpStrobe_t  strobe;
  logic       memHit, cfgHit, delayDone, atBoundary;
  logic [1:0] waitCycles;

  devsel_claim_dp #(
    .ADDR_W   (32),
    .BASE_ADDR(BASE_ADDR),
    .WIN_BITS (WIN_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .adBus       (adBus),
    .cbeN        (cbeN),
    .idsel       (idsel),
    .timingSel   (timingSel),
    .strobe      (strobe),
    .memHit      (memHit),
    .cfgHit      (cfgHit),
    .waitCycles  (waitCycles),
    .delayDone   (delayDone),
    .atBoundary  (atBoundary),
    .statusTiming(statusTiming)
  );

  devsel_claim_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .dataReady (dataReady),
    .abortReq  (abortReq),
    .memHit    (memHit),
    .cfgHit    (cfgHit),
    .waitCycles(waitCycles),
    .delayDone (delayDone),
    .atBoundary(atBoundary),
    .strobe    (strobe),
    .devselN   (devselN),
    .trdyN     (trdyN),
    .stopN     (stopN)
  );

endmodule

// File: tb/devsel_claim_bench.sv
`timescale 1ns/1ps
module devsel_claim_bench;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int WINB = 12;
  localparam int NVEC = 12;

  // {addr[31:0], cmd[3:0], idsel, timing[1:0], phases[3:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {32'h4000_0010, 4'b0111, 1'b0, 2'b00, 4'd1},
    {32'h4000_0100, 4'b0110, 1'b0, 2'b01, 4'd3},
    {32'h4000_0200, 4'b0111, 1'b0, 2'b10, 4'd2},
    {32'h4000_0300, 4'b0110, 1'b0, 2'b11, 4'd1},
    {32'h5000_0000, 4'b0111, 1'b0, 2'b00, 4'd1},
    {32'h4000_0040, 4'b0010, 1'b0, 2'b00, 4'd1},
    {32'h4000_0FF8, 4'b0111, 1'b0, 2'b00, 4'd4},
    {32'h0000_0004, 4'b1010, 1'b1, 2'b00, 4'd1},
    {32'h0000_0008, 4'b1011, 1'b0, 2'b00, 4'd1},
    {32'h0000_0105, 4'b1010, 1'b1, 2'b00, 4'd1},
    {32'h0000_0010, 4'b1011, 1'b1, 2'b01, 4'd2},
    {32'h4000_0FFC, 4'b0110, 1'b0, 2'b10, 4'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1;
  logic [31:0] adBus = '0;
  logic [3:0] cbeN = '0;
  logic idsel = 1'b0;
  logic [1:0] timingSel = 2'b00;
  logic dataReady = 1'b1, abortReq = 1'b0;
  logic devselN, trdyN, stopN;
  logic [1:0] statusTiming;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  devsel_claim #(.BASE_ADDR(BASE), .WIN_BITS(WINB)) u_devsel_claim (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .adBus(adBus),
    .cbeN(cbeN), .idsel(idsel), .timingSel(timingSel), .dataReady(dataReady),
    .abortReq(abortReq), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .statusTiming(statusTiming)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one transaction as initiator; called at a falling edge.
  task automatic runTxn(input logic [31:0] addr, input logic [3:0] cmd, input logic sel,
                        input logic [1:0] tim, input int phases, input int abortAfter,
                        output int delay, output int xfers, output bit disc,
                        output bit abortOk);
    logic pT, pS, pI, pF, prevD, d, t, s;
    bit abortRaised;
    logic [1:0] expStat;
    delay = 0; xfers = 0; disc = 1'b0; abortOk = 1'b0; abortRaised = 1'b0;
    adBus = addr; cbeN = cmd; idsel = sel; timingSel = tim; frameN = 1'b0; irdyN = 1'b1;
    #0.1;
    expStat = (tim == 2'b11) ? 2'b10 : tim;
    check(statusTiming == expStat, "R5 status code", statusTiming, expStat);
    @(negedge clk);
    adBus = '0; cbeN = 4'h0; idsel = 1'b0; irdyN = 1'b0;
    frameN = (phases <= 1);
    pT = 1'b1; pS = 1'b1; pI = 1'b1; pF = 1'b0; prevD = 1'b1;
    for (int k = 1; k < 40; k++) begin
      if (k > 1) @(negedge clk);
      d = devselN; t = trdyN; s = stopN;
      if (k > 1) begin
        if (!pT && !pI) xfers++;
        if (pF && !pI && (!pT || !pS)) begin
          check(d && t && s, "R7 release together", {d, t, s}, 7);
          if (!abortRaised) check(prevD == 1'b0, "R7 devsel held to end", prevD, 0);
          frameN = 1'b1; irdyN = 1'b1;
          break;
        end
      end
      if (delay == 0 && !d) delay = k;
      if (!s && !d) disc = 1'b1;
      if (abortRaised && !s && d && !prevD) abortOk = 1'b1;
      if (!t && d) check(1'b0, "R6 trdy before devsel", k, 0);
      if (!s && d && !abortRaised) check(1'b0, "R6 stop before devsel", k, 0);
      if (delay == 0 && k >= 6) begin
        frameN = 1'b1; irdyN = 1'b1;
        break;
      end
      if (!s) frameN = 1'b1;
      else frameN = (xfers >= phases - 1);
      if (abortAfter > 0 && xfers >= abortAfter && !abortRaised) begin
        abortReq = 1'b1; abortRaised = 1'b1;
      end
      pT = t; pS = s; pI = irdyN; pF = frameN; prevD = d;
    end
    abortReq = 1'b0;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int delay, xfers, room, expX, expDelay;
    bit disc, abOk, isMem, isCfg, claimExp;
    logic [42:0] v;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(devselN && trdyN && stopN, "R1 outputs in reset", {devselN, trdyN, stopN}, 7);
    rstN = 1'b1;
    @(negedge clk);
    check(devselN && trdyN && stopN, "R1 outputs after reset", {devselN, trdyN, stopN}, 7);
    @(negedge clk);

    // Table of vectors: R2, R3, R4, R8, R10
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      isMem = (v[10:7] == 4'b0110 || v[10:7] == 4'b0111) && (v[42:23] == BASE[31:12]);
      isCfg = (v[10:7] == 4'b1010 || v[10:7] == 4'b1011) && v[6] && (v[12:11] == 2'b00);
      claimExp = isMem || isCfg;
      room = isCfg ? 1 : 1024 - int'(v[22:13]);
      expX = claimExp ? ((int'(v[3:0]) < room) ? int'(v[3:0]) : room) : 0;
      expDelay = !claimExp ? 0 : (v[5:4] == 2'b00) ? 1 : (v[5:4] == 2'b01) ? 2 : 3;
      runTxn(v[42:11], v[10:7], v[6], v[5:4], int'(v[3:0]), 0, delay, xfers, disc, abOk);
      check(delay == expDelay, "R2/R3/R4 claim and delay", delay, expDelay);
      check(xfers == expX, "R8/R10 transfers", xfers, expX);
      check(disc == (claimExp && int'(v[3:0]) > room), "R8 disconnect", disc,
            claimExp && int'(v[3:0]) > room);
      repeat (2) @(negedge clk);
    end

    // R9 target-abort during a burst
    runTxn(32'h4000_0400, 4'b0111, 1'b0, 2'b00, 6, 1, delay, xfers, disc, abOk);
    check(abOk, "R9 abort drops devsel with stop", abOk, 1);
    check(devselN && trdyN && stopN, "R9 idle after abort", {devselN, trdyN, stopN}, 7);
    repeat (2) @(negedge clk);

    // R10 back-to-back address with no idle clock is not claimed
    runTxn(32'h4000_0020, 4'b0111, 1'b0, 2'b00, 1, 0, delay, xfers, disc, abOk);
    frameN = 1'b0; adBus = 32'h4000_0030; cbeN = 4'b0111;
    @(negedge clk);
    irdyN = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(devselN, "R10 no claim without idle clock", devselN, 1);
      @(negedge clk);
    end
    frameN = 1'b1; irdyN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 claim works again after idle
    runTxn(32'h4000_0050, 4'b0110, 1'b0, 2'b00, 2, 0, delay, xfers, disc, abOk);
    check(delay == 1 && xfers == 2, "R10 claim after idle", delay * 10 + xfers, 12);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule